// File: doc/BRIEF.md
# Banked Shadow Register File

This block is a general-purpose register file that holds several complete banks. Bank 0 is the normal bank. Banks 1 through `NUM_SHADOW` are shadow banks, so an interrupt handler can run in its own register context without saving the interrupted one. Two read ports and one write port serve normal instruction execution. All three address the bank named by the current-set field `cur_set`.

A second access path exists for system software. It has one read port and one write port, and it addresses the bank named by the previous-set field `prev_set`. Software first loads `prev_set` with the bank it wants, then inspects or fills any register of that bank.

The block also contains the logic that updates both set fields. An interrupt entry moves the old current set into `prev_set` and selects the requested bank. An exception return restores the current set from `prev_set`. A bank number beyond the configured range is forced to 0 and flagged.

Top module: `shadow_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cur_set` and `prev_set` are 0 and `bank_err` is 0.
- R2: Register index 0 reads as zero on `rd_a_data`, `rd_b_data` and `x_rd_data` in every bank. Writes to index 0 through either write port are ignored.
- R3: A normal write (`wr_en`) stores `wr_data` at index `wr_idx` of bank `cur_set`. The value reads back on both normal read ports in later cycles. A write into one bank leaves the same index of every other bank unchanged.
- R4: When `irq_take` is high at a clock edge, `prev_set` takes the old `cur_set` and `cur_set` takes `irq_bank`, both at that edge.
- R5: When `eret` is high and `irq_take` is low, `cur_set` takes the value of `prev_set` at the clock edge, and `prev_set` is unchanged.
- R6: A bank number greater than `NUM_SHADOW` is replaced by 0. This applies to `irq_bank` during `irq_take` and to `set_prev_val` during `set_prev_en`. `bank_err` is then high for exactly the one cycle after that edge.
- R7: A normal read whose index matches a same-cycle normal write to a nonzero index returns `wr_data` in that same cycle (write-first).
- R8: The cross-bank path reads (`x_rd_idx`) and writes (`x_wr_en`, `x_wr_idx`, `x_wr_data`) the bank named by `prev_set`, whatever the value of `cur_set`.
- R9: `set_prev_en` loads `prev_set` from `set_prev_val`. The priority is `irq_take` over `eret` over `set_prev_en`, so a lower-priority request in the same cycle is ignored. With none of the three asserted, both fields hold.
- R10: If both write ports target the same bank and index in one cycle, the normal write is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the set fields |
| rd_a_idx | input | 5 | Normal read port A index |
| rd_a_data | output | 32 | Normal read port A data |
| rd_b_idx | input | 5 | Normal read port B index |
| rd_b_data | output | 32 | Normal read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 5 | Normal write index |
| wr_data | input | 32 | Normal write data |
| x_rd_idx | input | 5 | Cross-bank read index (bank `prev_set`) |
| x_rd_data | output | 32 | Cross-bank read data |
| x_wr_en | input | 1 | Cross-bank write enable |
| x_wr_idx | input | 5 | Cross-bank write index |
| x_wr_data | input | 32 | Cross-bank write data |
| irq_take | input | 1 | Interrupt entry into bank `irq_bank` |
| irq_bank | input | 6 | Requested bank for interrupt entry |
| eret | input | 1 | Exception return pulse |
| set_prev_en | input | 1 | Load `prev_set` from software |
| set_prev_val | input | 6 | Bank number for `set_prev_en` |
| cur_set | output | 6 | Current-set field |
| prev_set | output | 6 | Previous-set field |
| bank_err | output | 1 | One-cycle flag for an out-of-range bank number |

## Verification
The bench builds the block with `NUM_SHADOW` = 3, giving four banks of 32 registers. With that setting the 6-bit bank fields can carry values from 4 to 63, so the clamp and the error flag can be driven from both the interrupt request and the software load. The small bank count also lets one short directed run switch between banks 0 and 2. Within that run it shows that the banks stay independent, and that the cross-bank path reaches a bank other than the current one.

// File: rtl/shadow_regbank.sv
module shadow_regbank #(
  parameter int NUM_SHADOW = 3,
  parameter int XLEN       = 32,
  parameter int NREG       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [4:0]       rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [4:0]       wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [4:0]       x_rd_idx,
  output logic [XLEN-1:0]  x_rd_data,
  input  logic             x_wr_en,
  input  logic [4:0]       x_wr_idx,
  input  logic [XLEN-1:0]  x_wr_data,
  input  logic             irq_take,
  input  logic [5:0]       irq_bank,
  input  logic             eret,
  input  logic             set_prev_en,
  input  logic [5:0]       set_prev_val,
  output logic [5:0]       cur_set,
  output logic [5:0]       prev_set,
  output logic             bank_err
);
  localparam int NBANK = NUM_SHADOW + 1;
  localparam int DEPTH = NBANK * NREG;
  localparam int FW    = $clog2(DEPTH);
  localparam logic [5:0] TOP = 6'(NUM_SHADOW);

  logic [XLEN-1:0] mem [DEPTH];
  logic [5:0] cur_n, prev_n;
  logic       err_n;

  function automatic logic [FW-1:0] loc(input logic [5:0] b, input logic [4:0] r);
    return FW'(b) * FW'(NREG) + FW'(r);
  endfunction

  function automatic logic [5:0] fit(input logic [5:0] b);
    return (b > TOP) ? 6'd0 : b;
  endfunction

  always_comb begin
    cur_n  = cur_set;
    prev_n = prev_set;
    err_n  = 1'b0;
    if (irq_take) begin
      prev_n = cur_set;
      cur_n  = fit(irq_bank);
      err_n  = irq_bank > TOP;
    end else if (eret) begin
      cur_n = prev_set;
    end else if (set_prev_en) begin
      prev_n = fit(set_prev_val);
      err_n  = set_prev_val > TOP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_set  <= '0;
      prev_set <= '0;
      bank_err <= 1'b0;
    end else begin
      cur_set  <= cur_n;
      prev_set <= prev_n;
      bank_err <= err_n;
    end
  end

  // normal write placed last so it wins a same-cell collision
  always_ff @(posedge clk) begin
    if (x_wr_en && x_wr_idx != 5'd0) mem[loc(prev_set, x_wr_idx)] <= x_wr_data;
    if (wr_en && wr_idx != 5'd0)     mem[loc(cur_set, wr_idx)]    <= wr_data;
  end

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 :
                     (wr_en && wr_idx == rd_a_idx) ? wr_data : mem[loc(cur_set, rd_a_idx)];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 :
                     (wr_en && wr_idx == rd_b_idx) ? wr_data : mem[loc(cur_set, rd_b_idx)];
  assign x_rd_data = (x_rd_idx == 5'd0) ? '0 : mem[loc(prev_set, x_rd_idx)];

  p_irq_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> prev_set == $past(cur_set) &&
                 cur_set == (($past(irq_bank) > TOP) ? 6'd0 : $past(irq_bank)));

  p_eret_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && eret) |=> cur_set == $past(prev_set) && $stable(prev_set));

  p_clamp_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_bank > TOP) |=> bank_err && cur_set == 6'd0);

  p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_set <= TOP && prev_set <= TOP);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && !eret && !set_prev_en) |=> $stable(cur_set) && $stable(prev_set) && !bank_err);
endmodule

// File: tb/shadow_regbank_test.sv
module shadow_regbank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] rd_a_idx, rd_b_idx, wr_idx, x_rd_idx, x_wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, x_rd_data, x_wr_data;
  logic wr_en, x_wr_en, irq_take, eret, set_prev_en, bank_err;
  logic [5:0] irq_bank, set_prev_val, cur_set, prev_set;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  shadow_regbank #(.NUM_SHADOW(3)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; x_wr_en = 0; irq_take = 0; eret = 0; set_prev_en = 0;
    wr_idx = 0; x_wr_idx = 0; wr_data = 0; x_wr_data = 0;
    irq_bank = 0; set_prev_val = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic t_reset();
    idle(); rd_a_idx = 0; rd_b_idx = 0; x_rd_idx = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1 cur_set in reset", 32'(cur_set), 0);
    rst_n = 1'b1; step();
    chk("R1 cur_set", 32'(cur_set), 0);
    chk("R1 prev_set", 32'(prev_set), 0);
    chk("R1 bank_err", 32'(bank_err), 0);
  endtask

  task automatic t_basic_rw();
    wr_en = 1; wr_idx = 5; wr_data = 32'hA5A5_0005; step();
    rd_a_idx = 5; rd_b_idx = 5; #1;
    chk("R3 port A readback", rd_a_data, 32'hA5A5_0005);
    chk("R3 port B readback", rd_b_data, 32'hA5A5_0005);
    wr_en = 1; wr_idx = 0; wr_data = 32'hFFFF_FFFF; step();
    rd_b_idx = 0; #1;
    chk("R2 r0 normal read", rd_b_data, 0);
  endtask

  task automatic t_bypass();
    wr_en = 1; wr_idx = 9; wr_data = 32'hB00B_0009; rd_a_idx = 9; rd_b_idx = 0; #1;
    chk("R7 same-cycle bypass", rd_a_data, 32'hB00B_0009);
    chk("R2 r0 not bypassed", rd_b_data, 0);
    step();
  endtask

  task automatic t_irq_bank();
    irq_take = 1; irq_bank = 2; step();
    chk("R4 cur_set", 32'(cur_set), 2);
    chk("R4 prev_set", 32'(prev_set), 0);
    wr_en = 1; wr_idx = 5; wr_data = 32'hC0DE_0025; step();
    rd_a_idx = 5; x_rd_idx = 5; #1;
    chk("R3 bank2 readback", rd_a_data, 32'hC0DE_0025);
    chk("R8 cross read bank0", x_rd_data, 32'hA5A5_0005);
    x_wr_en = 1; x_wr_idx = 7; x_wr_data = 32'hD00D_0007; step();
    x_rd_idx = 7; #1;
    chk("R8 cross write readback", x_rd_data, 32'hD00D_0007);
    x_wr_en = 1; x_wr_idx = 0; x_wr_data = 32'h1234_5678; step();
    x_rd_idx = 0; #1;
    chk("R2 r0 cross read", x_rd_data, 0);
  endtask

  task automatic t_eret();
    eret = 1; step();
    chk("R5 cur_set restored", 32'(cur_set), 0);
    chk("R5 prev_set kept", 32'(prev_set), 0);
    rd_a_idx = 5; rd_b_idx = 7; #1;
    chk("R3 bank0 untouched by bank2 write", rd_a_data, 32'hA5A5_0005);
    chk("R8 cross write landed in bank0", rd_b_data, 32'hD00D_0007);
  endtask

  task automatic t_clamp();
    irq_take = 1; irq_bank = 9; step();
    chk("R6 irq clamp", 32'(cur_set), 0);
    chk("R6 err raised", 32'(bank_err), 1);
    step();
    chk("R6 err one cycle", 32'(bank_err), 0);
    set_prev_en = 1; set_prev_val = 50; step();
    chk("R6 prev clamp", 32'(prev_set), 0);
    chk("R6 err on prev load", 32'(bank_err), 1);
    set_prev_en = 1; set_prev_val = 3; step();
    chk("R6 top bank accepted", 32'(prev_set), 3);
    chk("R6 no err in range", 32'(bank_err), 0);
  endtask

  task automatic t_priority();
    step();
    chk("R9 idle hold prev", 32'(prev_set), 3);
    irq_take = 1; irq_bank = 1; eret = 1; set_prev_en = 1; set_prev_val = 2; step();
    chk("R9 irq over others cur", 32'(cur_set), 1);
    chk("R9 irq over others prev", 32'(prev_set), 0);
    eret = 1; set_prev_en = 1; set_prev_val = 2; step();
    chk("R9 eret over prev load cur", 32'(cur_set), 0);
    chk("R9 eret over prev load prev", 32'(prev_set), 0);
  endtask

  task automatic t_conflict();
    wr_en = 1; wr_idx = 11; wr_data = 32'hEEEE_0011;
    x_wr_en = 1; x_wr_idx = 11; x_wr_data = 32'hFFFF_0011; step();
    rd_a_idx = 11; #1;
    chk("R10 normal write wins", rd_a_data, 32'hEEEE_0011);
  endtask

  initial begin
    t_reset();
    t_basic_rw();
    t_bypass();
    t_irq_bank();
    t_eret();
    t_clamp();
    t_priority();
    t_conflict();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule